// File: doc/BRIEF.md
# USB Device Address Control Unit

This unit keeps the address state of a USB function controller. Firmware running on an attached microcontroller reaches it through a parallel port that carries a command code. One code writes an eight-bit address register and another reads it back. The register holds an enable flag and a seven-bit address. This programmable copy is what firmware sees and what it can change.

A second, active copy feeds the token matcher. Each write of the programmable copy arms a pending flag. The active copy only takes the programmed value when the transaction engine reports that the host has acknowledged the zero-length status packet that ends the Set Address request. A USB bus reset moves the active copy to address zero with the device enabled. It leaves the programmable copy untouched.

Token matching compares an incoming token address with the active copy. A match is reported only while the active enable is set.

Top module: `usb_devaddr_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the programmable copy, the active address, the active enable, the pending flag and rd_valid are all 0.
- R2: A command with code 0xB6 stores cmd_wdata in the programmable register, with bit 7 as the enable flag and bits 6:0 as the address. A command with code 0xB7 raises rd_valid on the next cycle, for one cycle, with the register on rd_data in that same bit layout.
- R3: A command with any code other than 0xB6 or 0xB7 changes neither the register nor the outputs, and it raises no rd_valid.
- R4: A write leaves act_addr and act_en unchanged and sets addr_pending on the next cycle. This holds even when it coincides with a bus reset or a commit.
- R5: A commit_ack while addr_pending is set, with no bus reset, loads the programmable enable and address (as they were before that edge) into the active copy. Without a coinciding write it also clears addr_pending.
- R6: A commit_ack while addr_pending is clear leaves the active copy unchanged.
- R7: A bus_reset sets act_addr to 0 and act_en to 1 on the next cycle. Without a coinciding write it clears addr_pending. It never alters the value read back through code 0xB7.
- R8: When bus_reset and commit_ack occur in the same cycle, the result is that of the bus reset alone.
- R9: tok_hit is high in the same cycle exactly when tok_valid is high, act_en is 1, and tok_addr equals act_addr. The programmable copy plays no part in it.
- R10: Read data always reflects the programmable copy, never the active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command code (0xB6 write, 0xB7 read) |
| cmd_wdata | input | 8 | Write data: bit 7 enable, bits 6:0 address |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| rd_data | output | 8 | Programmable register contents |
| bus_reset | input | 1 | USB bus reset detected |
| commit_ack | input | 1 | Host ACK of the zero-length status IN packet on endpoint 0 |
| tok_valid | input | 1 | Token address present |
| tok_addr | input | 7 | Address field of the incoming token |
| tok_hit | output | 1 | Token is addressed to this device |
| act_en | output | 1 | Active device enable |
| act_addr | output | 7 | Active device address |
| addr_pending | output | 1 | A written address is waiting for its commit |

## Verification
The assertions assume that at most one command arrives per cycle. They also assume that commit_ack and bus_reset are qualified by the engine that drives them, so they may overlap each other and overlap writes in any combination. The properties only check how these inputs interact, never their pattern over time. The random stimulus draws one operation per cycle. It raises bus reset and commit at low rates so that pending writes survive long enough to be committed. It also forces the coinciding cases (reset with commit, write with commit) in directed steps. Token addresses are biased toward the active and programmed addresses so that both hits and near-misses occur.

// File: rtl/usb_devaddr_pkg.sv
// Package: shared constants for the device address control unit.
// Assumes a seven-bit USB address and an eight-bit command code space.
package usb_devaddr_pkg;
    localparam int DEF_ADDR_W = 7;
    localparam int DEF_CODE_W = 8;
    localparam logic [DEF_CODE_W-1:0] DEF_WR_CODE = 8'hB6;
    localparam logic [DEF_CODE_W-1:0] DEF_RD_CODE = 8'hB7;
endpackage

// File: rtl/devaddr_cmd_dec.sv
// Module: decodes the command port into a write strobe and a read strobe.
// Assumes at most one command per cycle. Unknown codes yield no strobe.
module devaddr_cmd_dec #(
    parameter int                CODE_W  = usb_devaddr_pkg::DEF_CODE_W,
    parameter logic [CODE_W-1:0] WR_CODE = usb_devaddr_pkg::DEF_WR_CODE,
    parameter logic [CODE_W-1:0] RD_CODE = usb_devaddr_pkg::DEF_RD_CODE
) (
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              wr_stb,
    output logic              rd_stb
);
    // Compare the code against both command values.
    always_comb begin
        wr_stb = cmd_valid && (cmd_code == WR_CODE);
        rd_stb = cmd_valid && (cmd_code == RD_CODE);
    end
endmodule

// File: rtl/devaddr_prog_reg.sv
// Module: programmable address register seen by firmware, plus the read path.
// Assumes wr_stb and rd_stb are never both high. A bus reset is not an input here,
// so the stored value survives bus resets by construction.
module devaddr_prog_reg #(
    parameter int ADDR_W = usb_devaddr_pkg::DEF_ADDR_W,
    localparam int REG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [REG_W-1:0]  wr_data,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data
);
    // Store enable and address on a write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_en   <= 1'b0;
            prog_addr <= '0;
        end else if (wr_stb) begin
            prog_en   <= wr_data[REG_W-1];
            prog_addr <= wr_data[ADDR_W-1:0];
        end
    end

    // Present the register one cycle after a read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= {prog_en, prog_addr};
        end
    end
endmodule

// File: rtl/devaddr_active_reg.sv
// Module: active address copy used by token matching, and the pending flag.
// Assumes commit arrives as a single-cycle pulse. The bus reset wins over a commit,
// and a write in the same cycle as either one still arms pending.
module devaddr_active_reg #(
    parameter int ADDR_W = usb_devaddr_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              commit,
    input  logic              bus_reset,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic              act_en,
    output logic [ADDR_W-1:0] act_addr,
    output logic              pending
);
    // Update the active copy on a bus reset or on a qualified commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en   <= 1'b0;
            act_addr <= '0;
        end else if (bus_reset) begin
            act_en   <= 1'b1;
            act_addr <= '0;
        end else if (commit && pending) begin
            act_en   <= prog_en;
            act_addr <= prog_addr;
        end
    end

    // Track whether a written address still awaits its commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pending <= 1'b0;
        else if (wr_stb)               pending <= 1'b1;
        else if (bus_reset || commit)  pending <= 1'b0;
    end
endmodule

// File: rtl/devaddr_tok_match.sv
// Module: combinational token address comparator against the active copy.
// Assumes tok_addr is stable while tok_valid is high.
module devaddr_tok_match #(
    parameter int ADDR_W = usb_devaddr_pkg::DEF_ADDR_W
) (
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic              act_en,
    input  logic [ADDR_W-1:0] act_addr,
    output logic              tok_hit
);
    // Report a hit only for an enabled device with an equal address.
    always_comb tok_hit = tok_valid && act_en && (tok_addr == act_addr);
endmodule

// File: rtl/usb_devaddr_ctrl.sv
// Module: top of the device address control unit. It joins the command decode,
// the programmable register, the active copy and the token comparator.
// Assumes a single clock domain, with all inputs synchronous to clk.
module usb_devaddr_ctrl #(
    parameter int                CODE_W  = usb_devaddr_pkg::DEF_CODE_W,
    parameter int                ADDR_W  = usb_devaddr_pkg::DEF_ADDR_W,
    parameter logic [CODE_W-1:0] WR_CODE = usb_devaddr_pkg::DEF_WR_CODE,
    parameter logic [CODE_W-1:0] RD_CODE = usb_devaddr_pkg::DEF_RD_CODE,
    localparam int               REG_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [REG_W-1:0]  cmd_wdata,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data,
    input  logic              bus_reset,
    input  logic              commit_ack,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic              tok_hit,
    output logic              act_en,
    output logic [ADDR_W-1:0] act_addr,
    output logic              addr_pending
);
    logic              wr_stb;
    logic              rd_stb;
    logic              prog_en;
    logic [ADDR_W-1:0] prog_addr;

    devaddr_cmd_dec #(.CODE_W(CODE_W), .WR_CODE(WR_CODE), .RD_CODE(RD_CODE)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    devaddr_prog_reg #(.ADDR_W(ADDR_W)) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wr_data   (cmd_wdata),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    devaddr_active_reg #(.ADDR_W(ADDR_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .commit    (commit_ack),
        .bus_reset (bus_reset),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .act_en    (act_en),
        .act_addr  (act_addr),
        .pending   (addr_pending)
    );

    devaddr_tok_match #(.ADDR_W(ADDR_W)) u_match (
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .act_en    (act_en),
        .act_addr  (act_addr),
        .tok_hit   (tok_hit)
    );
endmodule

// File: rtl/usb_devaddr_ctrl_chk.sv
// Module: property checker for the device address control unit, bound to the top.
// Assumes only port-level visibility. All properties are disabled during reset.
module usb_devaddr_ctrl_chk #(
    parameter int                CODE_W  = 8,
    parameter int                ADDR_W  = 7,
    parameter logic [CODE_W-1:0] WR_CODE = 8'hB6,
    parameter logic [CODE_W-1:0] RD_CODE = 8'hB7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic              rd_valid,
    input logic              bus_reset,
    input logic              commit_ack,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic              tok_hit,
    input logic              act_en,
    input logic [ADDR_W-1:0] act_addr,
    input logic              addr_pending
);
    logic is_wr;
    logic is_rd;
    assign is_wr = cmd_valid && (cmd_code == WR_CODE);
    assign is_rd = cmd_valid && (cmd_code == RD_CODE);

    // R2: a read command yields rd_valid on the next cycle
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);

    // R3: without a read command there is no read data
    a_r3_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rd_valid);

    // R4: a write alone leaves the active copy alone and arms pending
    a_r4_write_holds_active: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !bus_reset && !commit_ack) |=>
            ($stable(act_addr) && $stable(act_en) && addr_pending));

    // R5: a qualified commit without a write clears pending
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ack && addr_pending && !is_wr) |=> !addr_pending);

    // R6: commit with nothing pending changes nothing
    a_r6_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ack && !addr_pending && !bus_reset) |=>
            ($stable(act_addr) && $stable(act_en)));

    // R7 and R8: a bus reset forces address zero and enable, even over a commit
    a_r7_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (act_addr == '0 && act_en));

    // R9: a disabled device never matches, and an idle token bus never matches
    a_r9_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_en || !tok_valid) |-> !tok_hit);

    // R9: a hit implies equal addresses
    a_r9_hit_equal: assert property (@(posedge clk) disable iff (!rst_n)
        tok_hit |-> (tok_addr == act_addr));
endmodule

bind usb_devaddr_ctrl usb_devaddr_ctrl_chk #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .WR_CODE(WR_CODE), .RD_CODE(RD_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .rd_valid     (rd_valid),
    .bus_reset    (bus_reset),
    .commit_ack   (commit_ack),
    .tok_valid    (tok_valid),
    .tok_addr     (tok_addr),
    .tok_hit      (tok_hit),
    .act_en       (act_en),
    .act_addr     (act_addr),
    .addr_pending (addr_pending)
);

// File: tb/usb_devaddr_ctrl_tb.sv
`timescale 1ns/1ps
module usb_devaddr_ctrl_tb;
    localparam logic [7:0] WR = 8'hB6;
    localparam logic [7:0] RD = 8'hB7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       bus_reset = 1'b0;
    logic       commit_ack = 1'b0;
    logic       tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic       tok_hit;
    logic       act_en;
    logic [6:0] act_addr;
    logic       addr_pending;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic       m_pen;
    logic [6:0] m_paddr;
    logic       m_aen;
    logic [6:0] m_aaddr;
    logic       m_pend;

    always #2 clk = ~clk;

    usb_devaddr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_reset(bus_reset), .commit_ack(commit_ack), .tok_valid(tok_valid),
        .tok_addr(tok_addr), .tok_hit(tok_hit), .act_en(act_en),
        .act_addr(act_addr), .addr_pending(addr_pending)
    );

    function automatic logic exp_hit(input logic tv, input logic [6:0] ta);
        return tv && m_aen && (ta == m_aaddr);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive, check the combinational hit, clock, advance the model, check outputs.
    task automatic step(input logic cv, input logic [7:0] code, input logic [7:0] wd,
                        input logic br, input logic cm, input logic tv, input logic [6:0] ta);
        logic rv_e;
        logic [7:0] rd_e;
        logic wr;
        @(negedge clk);
        cmd_valid = cv; cmd_code = code; cmd_wdata = wd;
        bus_reset = br; commit_ack = cm; tok_valid = tv; tok_addr = ta;
        #1;
        check("R9 tok_hit", {31'd0, tok_hit}, {31'd0, exp_hit(tv, ta)});
        @(posedge clk);
        #1;
        wr   = cv && code == WR;
        rv_e = cv && code == RD;
        rd_e = {m_pen, m_paddr};
        if (br) begin
            m_aen = 1'b1; m_aaddr = '0;
        end else if (cm && m_pend) begin
            m_aen = m_pen; m_aaddr = m_paddr;
        end
        if (wr) m_pend = 1'b1;
        else if (br || cm) m_pend = 1'b0;
        if (wr) begin
            m_pen = wd[7]; m_paddr = wd[6:0];
        end
        check("R2/R3 rd_valid", {31'd0, rd_valid}, {31'd0, rv_e});
        if (rv_e) check("R10 rd_data", {24'd0, rd_data}, {24'd0, rd_e});
        check("R5/R7/R8 act_en", {31'd0, act_en}, {31'd0, m_aen});
        check("R4/R6/R7 act_addr", {25'd0, act_addr}, {25'd0, m_aaddr});
        check("R4/R5 addr_pending", {31'd0, addr_pending}, {31'd0, m_pend});
    endtask

    task automatic rd_back(input string req, input logic [7:0] exp);
        step(1'b1, RD, 8'h00, 1'b0, 1'b0, 1'b0, 7'd0);
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_pen = 0; m_paddr = 0; m_aen = 0; m_aaddr = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 act_en", {31'd0, act_en}, 32'd0);
        check("R1 act_addr", {25'd0, act_addr}, 32'd0);
        check("R1 addr_pending", {31'd0, addr_pending}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        rd_back("R1 readback", 8'h00);

        // R4: write 0x85 leaves the active copy alone
        step(1'b1, WR, 8'h85, 1'b0, 1'b0, 1'b0, 7'd0);
        rd_back("R2 readback", 8'h85);
        // R3: unknown code ignored
        step(1'b1, 8'hB5, 8'hFF, 1'b0, 1'b0, 1'b0, 7'd0);
        rd_back("R3 unchanged", 8'h85);
        // R9: not enabled yet, so no hit
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 7'd0);
        // R5: commit loads 5 with enable
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 7'd5);
        check("R5 act_addr", {25'd0, act_addr}, 32'd5);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 7'd5);
        check("R9 hit on active", {31'd0, tok_hit}, 32'd1);
        // R7: bus reset after a new write clears pending and keeps the readback
        step(1'b1, WR, 8'h8A, 1'b0, 1'b0, 1'b0, 7'd0);
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 7'd10);
        rd_back("R7 prog kept", 8'h8A);
        // R6: commit with nothing pending
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 7'd10);
        check("R6 act_addr", {25'd0, act_addr}, 32'd0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 7'd10);
        check("R9 prog not used", {31'd0, tok_hit}, 32'd0);
        // R8: bus reset and commit together
        step(1'b1, WR, 8'h93, 1'b0, 1'b0, 1'b0, 7'd0);
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 7'd0);
        check("R8 act_addr", {25'd0, act_addr}, 32'd0);
        check("R8 act_en", {31'd0, act_en}, 32'd1);
        // R4: write together with a commit commits the older value, pending stays
        step(1'b1, WR, 8'h11, 1'b0, 1'b0, 1'b0, 7'd0);
        step(1'b1, WR, 8'h22, 1'b0, 1'b1, 1'b0, 7'd0);
        check("R4 old value committed", {24'd0, act_en, act_addr}, 32'h11);
        rd_back("R10 prog not active", 8'h22);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic cv, br, cm, tv;
            logic [7:0] code;
            logic [7:0] wd;
            logic [6:0] ta;
            op = $urandom_range(0, 9);
            cv = op < 6;
            case ($urandom_range(0, 3))
                0, 1: code = WR;
                2:    code = RD;
                default: code = 8'($urandom_range(0, 255));
            endcase
            wd = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 1) == 1) wd[6:0] = 7'($urandom_range(0, 3));
            br = ($urandom_range(0, 19) == 0);
            cm = ($urandom_range(0, 5) == 0);
            tv = ($urandom_range(0, 1) == 1);
            case ($urandom_range(0, 2))
                0:       ta = m_aaddr;
                1:       ta = m_paddr;
                default: ta = 7'($urandom_range(0, 3));
            endcase
            step(cv, code, wd, br, cm, tv, ta);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule